// File: doc/BRIEF.md
# Microcoded Datapath ALU Unit

A combinational 32-bit arithmetic/logic unit for a small microprogrammed stack machine. A 6-bit control word chooses one of four functions (AND, OR, NOT of B, add), gates each operand on or off, can complement the A operand, and supplies a carry-in to the adder. The A operand comes from the holding register and the B operand from the B bus. The result leaves the block combinationally.

Two status flags are derived from the result: a negative flag (result bit 31) and a zero flag (all result bits zero). Both flags are captured in flip-flops on the rising clock edge, so the next-address logic sees them in the cycle after the microinstruction that produced them. The carry-in acts on the adder alone. A control word that ORs two disabled operands with the increment bit set therefore yields zero. A word that adds two disabled operands with the increment bit set yields one.

Top module: `dp_alu_unit`

## Requirements
- R1: The control word ctl[5:0] is read from most to least significant as sel_hi, sel_lo, use_a, use_b, neg_a, carry_in.
- R2: When use_a is 0 the A operand is forced to zero. When use_b is 0 the B operand is forced to zero. This happens before any function is applied.
- R3: When neg_a is 1, the gated A operand is replaced by its one's complement before the function unit.
- R4: sel = {sel_hi, sel_lo}. A value of 00 gives bitwise AND of the operands, 01 gives bitwise OR, and 10 gives the bitwise NOT of the gated B operand.
- R5: sel = 11 gives the 32-bit sum of the operands plus carry_in, modulo 2^32.
- R6: carry_in has no effect on the AND, OR and NOT-B results. Control 6'b010001 yields 0.
- R7: Control 6'b110001 yields 1. With neg_a and carry_in set, sel = 11 computes B - A.
- R8: flag_n_q takes result bit 31, and flag_z_q takes 1 when the result is all zeros. Both are registered on the rising clock edge and visible from the following cycle.
- R9: A synchronous active-high reset clears flag_n_q and flag_z_q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl | input | 6 | Control word {sel_hi, sel_lo, use_a, use_b, neg_a, carry_in} |
| opnd_a | input | 32 | A operand (holding register) |
| opnd_b | input | 32 | B operand (B bus) |
| result | output | 32 | Combinational ALU result |
| flag_n_q | output | 1 | Registered negative flag |
| flag_z_q | output | 1 | Registered zero flag |

## Verification
The result is due in the same cycle as its control word and operands. The bench drives inputs just after the falling edge and samples result a few time units later, before the next rising edge. The flags lag by exactly one rising edge. After that edge the bench compares them with the values it computed from the previous stimulus. Reset clearing is checked in the cycle after the reset edge.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
    localparam int CTL_W = 6;

    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_NOTB = 2'b10,
        FN_ADD  = 2'b11
    } alu_fn_e;

    typedef struct packed {
        alu_fn_e fn;
        logic    use_a;
        logic    use_b;
        logic    neg_a;
        logic    carry_in;
    } alu_ctl_t;

    typedef struct packed {
        logic n;
        logic z;
    } alu_flags_t;
endpackage

// File: rtl/dp_alu_opgate.sv
module dp_alu_opgate #(
    parameter int W = 32
) (
    input  logic         use_a,
    input  logic         use_b,
    input  logic         neg_a,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out
);
    logic [W-1:0] a_gated;

    always_comb begin
        a_gated = use_a ? a_in : '0;
        a_out   = neg_a ? ~a_gated : a_gated;
        b_out   = use_b ? b_in : '0;
    end

    // R2: a disabled B operand reaches the function unit as zero
    always_comb begin
        if (!use_b) p_b_gated_r2: assert (b_out == '0);
    end
endmodule

// File: rtl/dp_alu_fn.sv
module dp_alu_fn
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_fn_e      fn,
    input  logic         carry_in,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W-1:0] sum;

    always_comb begin
        sum = a + b + {{(W-1){1'b0}}, carry_in};
        unique case (fn)
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_NOTB: y = ~b;
            FN_ADD:  y = sum;
            default: y = '0;
        endcase
    end

    // R6: the logic functions do not see carry_in
    always_comb begin
        if (fn == FN_OR)   p_or_no_inc_r6:   assert (y == (a | b));
        if (fn == FN_AND)  p_and_no_inc_r6:  assert (y == (a & b));
        if (fn == FN_NOTB) p_notb_no_inc_r6: assert (y == ~b);
    end
endmodule

// File: rtl/dp_alu_unit.sv
module dp_alu_unit
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CTL_W-1:0] ctl,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    output logic [W-1:0]     result,
    output logic             flag_n_q,
    output logic             flag_z_q
);
    localparam int MSB = W - 1;

    alu_ctl_t     ctl_s;
    logic [W-1:0] a_op;
    logic [W-1:0] b_op;
    logic [W-1:0] y;
    alu_flags_t   flags_d;
    alu_flags_t   flags_q;

    assign ctl_s = alu_ctl_t'(ctl);

    dp_alu_opgate #(.W(W)) i_gate (
        .use_a (ctl_s.use_a),
        .use_b (ctl_s.use_b),
        .neg_a (ctl_s.neg_a),
        .a_in  (opnd_a),
        .b_in  (opnd_b),
        .a_out (a_op),
        .b_out (b_op)
    );

    dp_alu_fn #(.W(W)) i_fn (
        .fn       (ctl_s.fn),
        .carry_in (ctl_s.carry_in),
        .a        (a_op),
        .b        (b_op),
        .y        (y)
    );

    always_comb begin
        flags_d   = flags_q;
        flags_d.n = y[MSB];
        flags_d.z = (y == '0);
        if (rst) flags_d = '0;
    end

    always_ff @(posedge clk) begin
        flags_q <= flags_d;
    end

    assign result   = y;
    assign flag_n_q = flags_q.n;
    assign flag_z_q = flags_q.z;

    // R8: registered flags follow the previous cycle's result
    p_flags_follow_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (flag_n_q == $past(result[MSB]))
                        && (flag_z_q == ($past(result) == '0)));

    // R9: reset clears both flags
    p_reset_clears_r9: assert property (@(posedge clk)
        $past(rst) |-> (!flag_n_q && !flag_z_q));

    // R7: add of two disabled operands with carry gives one
    always_comb begin
        if (ctl == 6'b110001) p_inc_one_r7: assert (result == 1);
        if (ctl == 6'b010001) p_or_zero_r6: assert (result == '0);
    end
endmodule

// File: tb/test_dp_alu_unit.sv
module test_dp_alu_unit;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 0;
    logic         rst = 1;
    logic [5:0]   ctl = '0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] result;
    logic         flag_n_q;
    logic         flag_z_q;

    int n_tests = 0;
    int n_fail  = 0;
    logic [W-1:0] last_exp;
    bit done = 0;

    dp_alu_unit i_dp_alu_unit (
        .clk(clk), .rst(rst), .ctl(ctl), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result(result), .flag_n_q(flag_n_q), .flag_z_q(flag_z_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] ref_alu(logic [5:0] c, logic [W-1:0] a, logic [W-1:0] b);
        logic [W-1:0] ga, gb;
        ga = c[3] ? a : '0;
        if (c[1]) ga = ~ga;
        gb = c[2] ? b : '0;
        case (c[5:4])
            2'b00: return ga & gb;
            2'b01: return ga | gb;
            2'b10: return ~gb;
            default: return ga + gb + W'(c[0]);
        endcase
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive after negedge, check result mid-low, then flags after the next posedge
    task automatic apply(string req, logic [5:0] c, logic [W-1:0] a, logic [W-1:0] b);
        @(negedge clk);
        ctl = c; opnd_a = a; opnd_b = b;
        #1;
        last_exp = ref_alu(c, a, b);
        check(req, result, last_exp);
        @(posedge clk); #1;
        check("R8 flag_n", W'(flag_n_q), W'(last_exp[W-1]));
        check("R8 flag_z", W'(flag_z_q), W'(last_exp == '0));
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(posedge clk); #1;
        @(posedge clk); #1;
        check("R9 reset n", W'(flag_n_q), '0);
        check("R9 reset z", W'(flag_z_q), '0);
        @(negedge clk); rst = 0;

        apply("R6 or-zero-inc", 6'b010001, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check("R6 or-zero-inc literal", result, 32'h0);
        apply("R7 add-zero-inc", 6'b110001, 32'h1234_5678, 32'h9ABC_DEF0);
        check("R7 add-zero-inc literal", result, 32'h1);
        apply("R4 and", 6'b001100, 32'hF0F0_1234, 32'hFF00_FF00);
        check("R4 and literal", result, 32'hF000_1200);
        apply("R4 or", 6'b011100, 32'hF0F0_0000, 32'h0000_000F);
        check("R4 or literal", result, 32'hF0F0_000F);
        apply("R4 notb", 6'b100101, 32'h0, 32'h0000_00FF);
        check("R4/R6 notb literal", result, 32'hFFFF_FF00);
        apply("R6 and inc", 6'b001101, 32'h0000_0003, 32'h0000_0006);
        check("R6 and inc literal", result, 32'h2);
        apply("R5 add wrap", 6'b111100, 32'hFFFF_FFFF, 32'h0000_0001);
        check("R5 add wrap literal", result, 32'h0);
        apply("R7 sub", 6'b111111, 32'h0000_0005, 32'h0000_0003);
        check("R7 sub literal", result, 32'hFFFF_FFFE);
        apply("R3 inva", 6'b011010, 32'h0000_00FF, 32'h0);
        check("R3 inva literal", result, 32'hFFFF_FF00);
        apply("R2 b gated", 6'b111000, 32'h0000_0010, 32'hDEAD_BEEF);
        check("R2 b gated literal", result, 32'h10);
        apply("R1 field order", 6'b110101, 32'h1111_1111, 32'h0000_0007);
        check("R1 field order literal", result, 32'h8);

        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] ra, rb;
            ra = (i % 7 == 0) ? 32'h0 : $urandom;
            rb = (i % 5 == 0) ? 32'h8000_0000 : $urandom;
            apply("R5 random", 6'($urandom), ra, rb);
        end

        @(negedge clk); rst = 1;
        @(posedge clk); #1;
        check("R9 reset again n", W'(flag_n_q), '0);
        check("R9 reset again z", W'(flag_z_q), '0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule